// File: doc/BRIEF.md
# Precise Exception Status Tracker

This block follows each instruction of a five-stage in-order pipeline (fetch, decode, execute, memory access, writeback) and keeps an eight-bit fault vector beside it in every pipeline latch. A stage can raise fault strobes while it holds an instruction. Those strobes are ORed into that instruction's vector as it moves to the next stage. As soon as any bit of an instruction's vector is set, the block withholds that instruction's memory store and register-file write.

Faults are never acted on where they are raised. They are resolved only when the instruction holds the writeback latch. There the block raises a trap redirect, reports the highest-priority fault code and records the instruction's PC. In the same edge it empties every younger pipeline latch and drops the instruction being fetched. As a result, an older instruction's fault is always taken first, even when a younger instruction raised its own fault earlier in time.

The surrounding core presents each fetched instruction with its PC, the per-stage fault strobes, a global stall, and the store and register-write requests of the instructions in the memory and writeback stages. From the block it takes the gated write enables and the trap redirect.

Top module: `pext_tracker`

## Requirements
- R1: Fault sources map to fixed vector bits, and the bits accumulate as the instruction advances. `if_fault_i[0..2]` (instruction page fault, misaligned fetch, fetch protection) map to bits 0..2. `id_fault_i` (undefined opcode) maps to bit 3. `ex_fault_i` (arithmetic) maps to bit 4. `mem_fault_i[0..2]` (data page fault, misaligned data access, data protection) map to bits 5..7.
- R2: `trap_o` is high in exactly those cycles in which the writeback latch holds a valid instruction whose vector is nonzero.
- R3: On a trap, `cause_o` is loaded with the index (0..7) of the lowest set vector bit, so the earliest stage wins. It keeps its value in every cycle without a trap.
- R4: On a trap, `epc_o` is loaded with the PC of the trapping instruction and is held until the next trap.
- R5: An instruction's fault is taken before any fault of a later instruction, whatever the order in which the two were raised.
- R6: `rf_we_o` is high only for a valid writeback instruction with `wb_regwr_i` set and a clean vector. `mem_we_o` is high only for a valid memory-stage instruction with `mem_store_i` set, a clean vector, low `mem_fault_i`, and no trap in that cycle.
- R7: A trap empties all younger latches and discards the instruction at fetch. None of these instructions later traps or writes.
- R8: Fault strobes for a stage that holds no valid instruction are ignored.
- R9: While `stall_i` is high, the latches hold, fault strobes are ignored and both write enables are low. A pending trap is still taken.
- R10: After reset, all latches are empty, both write enables and `trap_o` are low, and `cause_o` and `epc_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Freeze all pipeline latches |
| if_valid_i | input | 1 | A valid instruction is being fetched |
| if_pc_i | input | PC_W | PC of the fetched instruction |
| if_fault_i | input | 3 | Fetch-stage fault strobes |
| id_fault_i | input | 1 | Decode-stage undefined-opcode strobe |
| ex_fault_i | input | 1 | Execute-stage arithmetic fault strobe |
| mem_fault_i | input | 3 | Memory-stage fault strobes |
| mem_store_i | input | 1 | Memory-stage instruction requests a store |
| wb_regwr_i | input | 1 | Writeback instruction requests a register write |
| mem_we_o | output | 1 | Gated memory store enable |
| rf_we_o | output | 1 | Gated register-file write enable |
| trap_o | output | 1 | Trap redirect: fetch the handler next |
| cause_o | output | 3 | Captured fault code |
| epc_o | output | PC_W | Captured PC of the trapping instruction |

## Verification
Single-fault patterns cover every bit at every program position, so a wrong bit mapping or a wrong trap cycle stands out. Two-fault patterns on one instruction test the priority order. Patterns with faults on two consecutive instructions, across all 64 combinations, include the cases where the younger instruction raises its fault first; these separate in-order resolution from first-come resolution. Stall patterns with forced all-ones strobes during stalls and on empty slots show whether stalled cycles or bubbles can leak faults or writes.

// File: rtl/pext_pkg.sv
package pext_pkg;
  localparam int CAUSE_N = 8;
  localparam int CODE_W  = $clog2(CAUSE_N);

  // strobe group widths and their positions in the carried vector
  localparam int IF_W    = 3;
  localparam int IF_LSB  = 0;
  localparam int ID_W    = 1;
  localparam int ID_LSB  = IF_LSB + IF_W;
  localparam int EX_W    = 1;
  localparam int EX_LSB  = ID_LSB + ID_W;
  localparam int MEM_W   = 3;
  localparam int MEM_LSB = EX_LSB + EX_W;

  typedef logic [CAUSE_N-1:0] cvec_t;
  typedef logic [CODE_W-1:0]  code_t;
endpackage

// File: rtl/pext_post.sv
module pext_post
  import pext_pkg::*;
#(
  parameter int SW  = 1,
  parameter int LSB = 0
) (
  input  logic          vld_i,
  input  logic [SW-1:0] stb_i,
  output cvec_t         post_o
);
  // place a stage's strobes at their vector position; bubbles post nothing
  always_comb begin
    post_o = '0;
    if (vld_i) post_o = cvec_t'(stb_i) << LSB;
  end
endmodule

// File: rtl/pext_prio.sv
module pext_prio
  import pext_pkg::*;
(
  input  cvec_t vec_i,
  output code_t code_o
);
  // lowest set bit wins: earliest stage has priority
  always_comb begin
    code_o = '0;
    for (int i = CAUSE_N - 1; i >= 0; i--) begin
      if (vec_i[i]) code_o = code_t'(i);
    end
  end
endmodule

// File: rtl/pext_stage.sv
module pext_stage
  import pext_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  input  logic            kill_i,
  input  logic            vld_d_i,
  input  logic [PC_W-1:0] pc_d_i,
  input  cvec_t           vec_d_i,
  output logic            vld_o,
  output logic [PC_W-1:0] pc_o,
  output cvec_t           vec_o
);
  logic            vld_n;
  logic [PC_W-1:0] pc_n;
  cvec_t           vec_n;

  always_comb begin
    vld_n = vld_o;
    pc_n  = pc_o;
    vec_n = vec_o;
    if (kill_i) begin
      vld_n = 1'b0;
      pc_n  = '0;
      vec_n = '0;
    end else if (adv_i) begin
      vld_n = vld_d_i;
      pc_n  = pc_d_i;
      vec_n = vec_d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      pc_o  <= '0;
      vec_o <= '0;
    end else begin
      vld_o <= vld_n;
      pc_o  <= pc_n;
      vec_o <= vec_n;
    end
  end
endmodule

// File: rtl/pext_tracker.sv
module pext_tracker
  import pext_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_i,
  input  logic             if_valid_i,
  input  logic [PC_W-1:0]  if_pc_i,
  input  logic [IF_W-1:0]  if_fault_i,
  input  logic             id_fault_i,
  input  logic             ex_fault_i,
  input  logic [MEM_W-1:0] mem_fault_i,
  input  logic             mem_store_i,
  input  logic             wb_regwr_i,
  output logic             mem_we_o,
  output logic             rf_we_o,
  output logic             trap_o,
  output logic [CODE_W-1:0] cause_o,
  output logic [PC_W-1:0]  epc_o
);
  localparam int NLATCH = 4;
  localparam int L_ID   = 0;
  localparam int L_EX   = 1;
  localparam int L_MEM  = 2;
  localparam int L_WB   = NLATCH - 1;

  logic            vld_q [NLATCH];
  logic [PC_W-1:0] pc_q  [NLATCH];
  cvec_t           vec_q [NLATCH];
  cvec_t           post  [NLATCH];

  logic take;
  logic adv;

  // strobe placement, index = stage that raises it
  pext_post #(.SW(IF_W),  .LSB(IF_LSB))  u_post_if  (.vld_i(if_valid_i),   .stb_i(if_fault_i),  .post_o(post[0]));
  pext_post #(.SW(ID_W),  .LSB(ID_LSB))  u_post_id  (.vld_i(vld_q[L_ID]),  .stb_i(id_fault_i),  .post_o(post[1]));
  pext_post #(.SW(EX_W),  .LSB(EX_LSB))  u_post_ex  (.vld_i(vld_q[L_EX]),  .stb_i(ex_fault_i),  .post_o(post[2]));
  pext_post #(.SW(MEM_W), .LSB(MEM_LSB)) u_post_mem (.vld_i(vld_q[L_MEM]), .stb_i(mem_fault_i), .post_o(post[3]));

  assign adv = ~stall_i;

  genvar k;
  generate
    for (k = 0; k < NLATCH; k++) begin : g_latch
      logic            d_vld;
      logic [PC_W-1:0] d_pc;
      cvec_t           d_vec;
      if (k == 0) begin : g_head
        assign d_vld = if_valid_i;
        assign d_pc  = if_pc_i;
        assign d_vec = post[0];
      end else begin : g_body
        assign d_vld = vld_q[k-1];
        assign d_pc  = pc_q[k-1];
        assign d_vec = vec_q[k-1] | post[k];
      end
      pext_stage #(.PC_W(PC_W)) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (adv),
        .kill_i (take),
        .vld_d_i(d_vld),
        .pc_d_i (d_pc),
        .vec_d_i(d_vec),
        .vld_o  (vld_q[k]),
        .pc_o   (pc_q[k]),
        .vec_o  (vec_q[k])
      );
    end
  endgenerate

  // resolution at writeback only
  logic wb_vld;
  logic [PC_W-1:0] wb_pc;
  cvec_t wb_vec;
  assign wb_vld = vld_q[L_WB];
  assign wb_pc  = pc_q[L_WB];
  assign wb_vec = vec_q[L_WB];
  assign take   = wb_vld & (wb_vec != '0);
  assign trap_o = take;

  code_t wb_code;
  pext_prio u_prio (.vec_i(wb_vec), .code_o(wb_code));

  // write gating
  assign rf_we_o  = wb_vld & wb_regwr_i & (wb_vec == '0) & ~stall_i;
  assign mem_we_o = vld_q[L_MEM] & mem_store_i & ((vec_q[L_MEM] | post[3]) == '0)
                    & ~take & ~stall_i;

  // exception record
  code_t           cause_n;
  logic [PC_W-1:0] epc_n;

  always_comb begin
    cause_n = cause_o;
    epc_n   = epc_o;
    if (take) begin
      cause_n = wb_code;
      epc_n   = wb_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_o <= '0;
      epc_o   <= '0;
    end else begin
      cause_o <= cause_n;
      epc_o   <= epc_n;
    end
  end
endmodule

// File: rtl/pext_tracker_chk.sv
module pext_tracker_chk
  import pext_pkg::*;
#(
  parameter int PC_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall_i,
  input logic              trap_o,
  input logic              rf_we_o,
  input logic              mem_we_o,
  input logic [CODE_W-1:0] cause_o,
  input logic [PC_W-1:0]   epc_o,
  input logic [PC_W-1:0]   wb_pc,
  input cvec_t             wb_vec
);
  a_r4_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> epc_o == $past(wb_pc));

  a_r3_record_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |=> $stable(cause_o) && $stable(epc_o));

  a_r7_flush_after_trap: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> !trap_o && !rf_we_o);

  a_r6_no_store_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !mem_we_o);

  a_r6_rf_only_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> wb_vec == '0);

  a_r9_stall_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> !rf_we_o && !mem_we_o);
endmodule

bind pext_tracker pext_tracker_chk #(.PC_W(PC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .stall_i (stall_i),
  .trap_o  (trap_o),
  .rf_we_o (rf_we_o),
  .mem_we_o(mem_we_o),
  .cause_o (cause_o),
  .epc_o   (epc_o),
  .wb_pc   (wb_pc),
  .wb_vec  (wb_vec)
);

// File: tb/pext_tracker_test.sv
module pext_tracker_test;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            stall_i;
  logic            if_valid_i;
  logic [PC_W-1:0] if_pc_i;
  logic [2:0]      if_fault_i;
  logic            id_fault_i;
  logic            ex_fault_i;
  logic [2:0]      mem_fault_i;
  logic            mem_store_i;
  logic            wb_regwr_i;
  logic            mem_we_o;
  logic            rf_we_o;
  logic            trap_o;
  logic [2:0]      cause_o;
  logic [PC_W-1:0] epc_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [2:0]      exp_cause;
  logic [PC_W-1:0] exp_epc;
  logic [PC_W-1:0] base;

  always #4 clk = ~clk;

  pext_tracker #(.PC_W(PC_W)) uut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .if_valid_i(if_valid_i),
    .if_pc_i(if_pc_i), .if_fault_i(if_fault_i), .id_fault_i(id_fault_i),
    .ex_fault_i(ex_fault_i), .mem_fault_i(mem_fault_i), .mem_store_i(mem_store_i),
    .wb_regwr_i(wb_regwr_i), .mem_we_o(mem_we_o), .rf_we_o(rf_we_o),
    .trap_o(trap_o), .cause_o(cause_o), .epc_o(epc_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] lowest(input logic [7:0] m);
    logic [2:0] r = 3'd0;
    for (int i = 7; i >= 0; i--) if (m[i]) r = 3'(i);
    return r;
  endfunction

  // Four-instruction program, one per cycle unless stalled.
  // Empty slots and stalled cycles get all-ones strobes (R8, R9).
  task automatic run_prog(input logic [7:0] m0, input logic [7:0] m1,
                          input logic [7:0] m2, input logic [7:0] m3,
                          input logic [15:0] stall_pat);
    logic [7:0] pm [4];
    int occ [5];
    int nxt = 0;
    bit stopped = 0;
    pm[0] = m0; pm[1] = m1; pm[2] = m2; pm[3] = m3;
    for (int s = 0; s < 5; s++) occ[s] = -1;
    base = base + 32'h100;
    for (int cyc = 0; cyc < 16; cyc++) begin
      bit st;
      bit e_take, e_rf, e_mem;
      @(negedge clk);
      st = stall_pat[cyc];
      occ[0] = (!stopped && nxt < 4) ? nxt : -1;
      stall_i     = st;
      if_valid_i  = occ[0] >= 0;
      if_pc_i     = (occ[0] >= 0) ? base + 32'(occ[0] * 4) : 32'hDEAD_0000;
      if_fault_i  = (st || occ[0] < 0) ? 3'b111 : pm[occ[0]][2:0];
      id_fault_i  = (st || occ[1] < 0) ? 1'b1   : pm[occ[1]][3];
      ex_fault_i  = (st || occ[2] < 0) ? 1'b1   : pm[occ[2]][4];
      mem_fault_i = (st || occ[3] < 0) ? 3'b111 : pm[occ[3]][7:5];
      mem_store_i = 1'b1;
      wb_regwr_i  = 1'b1;
      #1;
      e_take = (occ[4] >= 0) && (pm[occ[4]] != 8'h00);
      e_rf   = (occ[4] >= 0) && (pm[occ[4]] == 8'h00) && !st;
      e_mem  = (occ[3] >= 0) && (pm[occ[3]] == 8'h00) && !e_take && !st;
      check("R2/R5/R7/R8 trap", 32'(trap_o), 32'(e_take));
      check("R6/R9 rf_we", 32'(rf_we_o), 32'(e_rf));
      check("R6/R9 mem_we", 32'(mem_we_o), 32'(e_mem));
      check("R1/R3 cause", 32'(cause_o), 32'(exp_cause));
      check("R4 epc", epc_o, exp_epc);
      if (e_take) begin
        exp_cause = lowest(pm[occ[4]]);
        exp_epc   = base + 32'(occ[4] * 4);
        for (int s = 1; s < 5; s++) occ[s] = -1;
        stopped = 1;
      end else if (!st) begin
        for (int s = 4; s > 0; s--) occ[s] = occ[s-1];
        if (occ[0] >= 0) nxt++;
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; stall_i = 1'b0; if_valid_i = 1'b0; if_pc_i = '0;
    if_fault_i = '0; id_fault_i = 1'b0; ex_fault_i = 1'b0; mem_fault_i = '0;
    mem_store_i = 1'b1; wb_regwr_i = 1'b1;
    exp_cause = '0; exp_epc = '0; base = 32'h1000;
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    check("R10 trap", 32'(trap_o), 0);
    check("R10 rf_we", 32'(rf_we_o), 0);
    check("R10 mem_we", 32'(mem_we_o), 0);
    check("R10 cause", 32'(cause_o), 0);
    check("R10 epc", epc_o, 0);
    rst_n = 1'b1;

    // clean program: all writes happen (R6)
    run_prog(8'h00, 8'h00, 8'h00, 8'h00, 16'h0000);

    // R1/R3/R4: each bit at each position
    for (int b = 0; b < 8; b++)
      for (int p = 0; p < 4; p++)
        run_prog(p == 0 ? 8'(1 << b) : 8'h00, p == 1 ? 8'(1 << b) : 8'h00,
                 p == 2 ? 8'(1 << b) : 8'h00, p == 3 ? 8'(1 << b) : 8'h00, 16'h0000);

    // R3: two causes on one instruction, earliest stage reported
    for (int i = 0; i < 8; i++)
      for (int j = i + 1; j < 8; j++)
        run_prog(8'((1 << i) | (1 << j)), 8'h00, 8'h00, 8'h00, 16'h0000);

    // R5/R7: faults on consecutive instructions, older one wins
    for (int a = 0; a < 8; a++)
      for (int c = 0; c < 8; c++)
        run_prog(8'(1 << a), 8'(1 << c), 8'h00, 8'h00, 16'h0000);

    // R9: stalls, including a stall while a trap is pending
    run_prog(8'h00, 8'h00, 8'h00, 8'h00, 16'b0000_0000_0101_0110);
    run_prog(8'h00, 8'h20, 8'h00, 8'h00, 16'b0000_0000_0011_1010);
    run_prog(8'h10, 8'h01, 8'h00, 8'h00, 16'b0000_0000_0011_0000);
    run_prog(8'h00, 8'h00, 8'h08, 8'h00, 16'b0000_0001_1100_1001);
    run_prog(8'h00, 8'h80, 8'h04, 8'h00, 16'b0000_0000_0110_0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule